// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional Access

This block sits between a processor's data port and a single-ported word memory. It gives software an indivisible read-modify-write. A load-linked access reads a word and places a reservation on that word's address. A later store-conditional to the same word writes only if nothing has disturbed the reservation in between. The store-conditional then returns 1 for success or 0 for failure, so that software can loop and retry. Writes from other agents are seen through a snoop input and break a matching reservation. This makes a swap or increment built from the pair appear atomic to every other writer.

For stand-alone testing, the memory is an internal register array of `DEPTH` words. It is indexed by address bits `[IDX_W+1:2]`, so addresses beyond the array alias onto it. The reservation holds one valid bit and the full word address, bits `[31:2]`. Read data and the success flag are registered and appear one cycle after the access. The memory write enable is combinational and is high in the same cycle as the access that writes.

Top module: `llsc_monitor`

## Requirements
- R1: Access kind encoding is 00 load, 01 store, 10 load-linked, 11 store-conditional, qualified by `acc_valid`. A load drives `rd_data` with the addressed word one cycle later and never raises `mem_we`.
- R2: A store raises `mem_we` in its own cycle and writes `acc_wdata` into the word selected by address bits [5:2] (default depth 16). Later reads return that value.
- R3: A load-linked returns the addressed word one cycle later, does not write, and sets the reservation to the word address `acc_addr[31:2]`.
- R4: A store-conditional whose word address equals a valid reservation succeeds. It raises `mem_we`, writes memory, and one cycle later gives `rd_data` = 1 and `sc_ok` = 1.
- R5: A store-conditional with no valid reservation, or to a different word address, fails. `mem_we` stays low, memory is unchanged, and one cycle later `rd_data` = 0 and `sc_ok` = 0. `sc_ok` is 0 after any access that is not a successful store-conditional.
- R6: A local store to the reserved word clears the reservation. A store to any other word leaves it intact.
- R7: A snooped store (`snoop_valid` with `snoop_addr[31:2]` equal to the reserved word) clears the reservation. A snoop to another word has no effect.
- R8: Every store-conditional clears the reservation, whether it passes or fails.
- R9: A load-linked replaces any earlier reservation, so only the most recent load-linked address can succeed.
- R10: Reset clears the reservation, `rd_data` and `sc_ok`.
- R11: A snoop to the reserved word in the same cycle as a store-conditional makes it fail. A snoop to the same word as a load-linked in the same cycle does not prevent that reservation from being set.
- R12: Loads to any address leave the reservation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_kind | input | 2 | 00 load, 01 store, 10 load-linked, 11 store-conditional |
| acc_addr | input | 32 | Byte address, word aligned |
| acc_wdata | input | 32 | Store data |
| snoop_valid | input | 1 | Another agent stores this cycle |
| snoop_addr | input | 32 | Address of the snooped store |
| rd_data | output | 32 | Read word, or store-conditional result, one cycle after the access |
| mem_we | output | 1 | Memory write enable this cycle |
| sc_ok | output | 1 | Store-conditional success pulse, one cycle after the access |

## Verification
The assertions assume that `acc_kind` and the addresses carry known values whenever `acc_valid` or `snoop_valid` is high. They also assume that reset is held for at least one clock before any access. The stimulus drives every input on the falling edge with defined values. It holds reset for two cycles at the start and again in the middle of the run. It keeps all addresses word aligned and inside the array, so that no two distinct reserved addresses alias onto one memory word.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_we,
  output logic              sc_ok
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int WA_W  = ADDR_W - 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              resv_valid;
  logic [WA_W-1:0]   resv_addr;

  wire [WA_W-1:0]  word_addr = acc_addr[ADDR_W-1:2];
  wire [IDX_W-1:0] idx       = acc_addr[IDX_W+1:2];

  wire is_ld = acc_valid && acc_kind == 2'b00;
  wire is_st = acc_valid && acc_kind == 2'b01;
  wire is_ll = acc_valid && acc_kind == 2'b10;
  wire is_sc = acc_valid && acc_kind == 2'b11;

  wire resv_hit  = resv_valid && resv_addr == word_addr;
  wire snoop_hit = snoop_valid && resv_valid && snoop_addr[ADDR_W-1:2] == resv_addr;
  wire sc_pass   = is_sc && resv_hit && !snoop_hit;
  wire resv_kill = is_sc || (is_st && resv_hit) || snoop_hit;

  assign mem_we = is_st || sc_pass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      resv_addr  <= '0;
    end else if (is_ll) begin
      resv_valid <= 1'b1;
      resv_addr  <= word_addr;
    end else if (resv_kill) begin
      resv_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[idx] <= acc_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      sc_ok   <= 1'b0;
    end else begin
      sc_ok <= sc_pass;
      if (is_ld || is_ll) rd_data <= mem[idx];
      else if (is_sc)     rd_data <= {{(DATA_W-1){1'b0}}, sc_pass};
    end
  end
endmodule

module llsc_monitor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [1:0]        acc_kind,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              snoop_valid,
  input logic [ADDR_W-1:0] snoop_addr,
  input logic              mem_we,
  input logic              sc_ok,
  input logic              resv_valid,
  input logic [ADDR_W-3:0] resv_addr
);
  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_kind[0] |-> !mem_we); // R1
  AST_STORE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind == 2'b01 |-> mem_we); // R2
  AST_LL_RESERVES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind == 2'b10 |=> resv_valid && resv_addr == $past(acc_addr[ADDR_W-1:2])); // R3
  AST_SC_WRITE_NEEDS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind == 2'b11 && mem_we |-> resv_valid && resv_addr == acc_addr[ADDR_W-1:2]); // R4
  AST_OK_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sc_ok |-> $past(mem_we) && $past(acc_valid) && $past(acc_kind) == 2'b11); // R5
  AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid && resv_valid && snoop_addr[ADDR_W-1:2] == resv_addr
    && !(acc_valid && acc_kind == 2'b10) |=> !resv_valid); // R7
  AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind == 2'b11 |=> !resv_valid); // R8
  AST_SNOOP_BLOCKS_SC: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind == 2'b11 && snoop_valid && snoop_addr[ADDR_W-1:2] == acc_addr[ADDR_W-1:2]
    |-> !mem_we); // R11
endmodule

bind llsc_monitor llsc_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
  .acc_addr(acc_addr), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
  .mem_we(mem_we), .sc_ok(sc_ok), .resv_valid(resv_valid), .resv_addr(resv_addr)
);

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = 2'b00;
  logic [31:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic        snoop_valid = 1'b0;
  logic [31:0] snoop_addr = '0;
  logic [31:0] rd_data;
  logic        mem_we;
  logic        sc_ok;

  localparam logic [1:0] K_LD = 2'b00, K_ST = 2'b01, K_LL = 2'b10, K_SC = 2'b11;

  llsc_monitor dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .rd_data(rd_data), .mem_we(mem_we), .sc_ok(sc_ok)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] model_mem [16];
  logic        m_rv = 1'b0;
  logic [29:0] m_ra = '0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input logic av, input logic [1:0] k, input logic [31:0] a,
                    input logic [31:0] d, input logic sv, input logic [31:0] sa,
                    input string tag);
    logic pass, exp_we, shit;
    logic [31:0] exp_rd;
    acc_valid = av; acc_kind = k; acc_addr = a; acc_wdata = d;
    snoop_valid = sv; snoop_addr = sa;
    shit   = sv && m_rv && sa[31:2] == m_ra;
    pass   = av && k == K_SC && m_rv && m_ra == a[31:2] && !shit;
    exp_we = (av && k == K_ST) || pass;
    exp_rd = (k == K_SC) ? {31'b0, pass} : model_mem[a[5:2]];
    #1;
    check({tag, " mem_we"}, {31'b0, mem_we}, {31'b0, exp_we});
    @(posedge clk);
    if (exp_we) model_mem[a[5:2]] = d;
    if (av && k == K_LL) begin m_rv = 1'b1; m_ra = a[31:2]; end
    else if ((av && k == K_SC) || (av && k == K_ST && m_rv && m_ra == a[31:2]) || shit) m_rv = 1'b0;
    #1;
    if (av && k != K_ST) check({tag, " rd_data"}, rd_data, exp_rd);
    check({tag, " sc_ok"}, {31'b0, sc_ok}, {31'b0, pass});
    @(negedge clk);
    acc_valid = 1'b0; snoop_valid = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check("R10 rd_data after reset", rd_data, 32'h0);
    check("R10 sc_ok after reset", {31'b0, sc_ok}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) op(1, K_ST, i * 4, 32'hA500_0000 + i * 32'h1111, 0, 0, "R2");
    for (int i = 0; i < 16; i++) op(1, K_LD, i * 4, 0, 0, 0, "R1");
    op(1, K_SC, 32'h8, 32'hDEAD, 0, 0, "R5 no reservation");
    op(1, K_LD, 32'h8, 0, 0, 0, "R5 memory untouched");
    for (int a = 0; a < 8; a++)
      for (int t = 0; t < 5; t++)
        for (int b = 0; b < 8; b++) begin
          string tg;
          op(1, K_LL, a * 4, 0, 0, 0, "R3");
          case (t)
            0: begin tg = "R4";  op(0, K_LD, 0, 0, 0, 0, tg); end
            1: begin tg = "R12"; op(1, K_LD, b * 4, 0, 0, 0, tg); end
            2: begin tg = "R6";  op(1, K_ST, b * 4, 32'h5000 + a * 64 + b, 0, 0, tg); end
            3: begin tg = "R7";  op(0, K_LD, 0, 0, 1, b * 4, tg); end
            default: begin tg = "R9"; op(1, K_LL, b * 4, 0, 0, 0, tg); end
          endcase
          op(1, K_SC, a * 4, 32'hC000_0000 + a * 256 + t * 16 + b, 0, 0, {tg, " sc"});
          op(1, K_SC, a * 4, 32'hEEEE, 0, 0, "R8 second sc fails");
          op(1, K_LD, a * 4, 0, 0, 0, "R5 readback");
        end
    op(1, K_LL, 32'h10, 0, 0, 0, "R3");
    op(1, K_SC, 32'h14, 32'h77, 0, 0, "R5 address mismatch");
    op(1, K_LL, 32'h10, 0, 0, 0, "R3");
    op(1, K_SC, 32'h10, 32'h78, 1, 32'h10, "R11 snoop same cycle as sc");
    op(1, K_LL, 32'h18, 0, 1, 32'h18, "R11 snoop same cycle as ll");
    op(1, K_SC, 32'h18, 32'h79, 0, 0, "R11 reservation kept");
    op(1, K_LL, 32'h1C, 0, 0, 0, "R3");
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check("R10 sc_ok in reset", {31'b0, sc_ok}, 32'h0);
    m_rv = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    op(1, K_SC, 32'h1C, 32'h7A, 0, 0, "R10 reservation cleared");
    op(1, K_LD, 32'h1C, 0, 0, 0, "R10 memory kept");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule